// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block takes power-mode requests from software over a small register bus and reports the mode that is in effect. A permission register, writable only once after power-on reset, decides which of the reduced-power and boosted modes may ever be entered. Run-mode changes take effect in one clock. A stop request from the core starts a stop entry, provided the configured stop kind is permitted and the present run mode allows it.

A stop entry raises a request to four groups in a fixed order: bus masters, system-clock peripherals, bus-clock peripherals, then slow-clock peripherals. Each group's acknowledge moves the chain on by one stage. When the last group acknowledges, the clocks picked by the partial-stop option are gated and the block reports STOP. If a programmable limit runs out before the chain completes, the entry is dropped, a one-cycle timeout event is raised and the run mode is kept. A wake-up in STOP releases the groups in reverse order, one per cycle, and ends in normal RUN. An entry log records how far the most recent entries progressed.

Top module: `lp_mode_seq`

## Requirements
- R1: The permission register (address 0, bit0 high-speed run, bit1 very-low-power run and stop, bit2 low-leakage stop, bit3 very-low-leakage stop) resets to 0 and takes only the first write after reset. Later writes leave it unchanged.
- R2: `mode_o` and address 3 are one-hot: 0x01 normal RUN, 0x02 any stop (including stop exit), 0x04 very-low-power run, 0x80 high-speed run. After reset the value is 0x01.
- R3: A write to address 1 bits [1:0] requests a run mode: 0 normal, 2 very-low-power (needs bit1), 3 high-speed (needs bit0). Codes 2 and 3 are accepted only from normal RUN. Code 0 is accepted from any run mode. An accepted request takes effect at the next edge.
- R4: A refused request is ignored and sets the sticky error flag (`err_o`, address 6 bit0), which only reset clears. Refused requests are: a code that is not permitted, an illegal transition, run code 1, a run write outside a run mode, an invalid stop kind, or a stop request from high-speed run.
- R5: Address 2 holds the stop kind in bits [2:0] (0 normal, 2 very-low-power needs bit1, 3 low-leakage needs bit2, 4 very-low-leakage needs bit3) and the partial option in bits [4:3]. A `sleep_req` seen in normal or very-low-power run starts an entry with these settings.
- R6: During an entry, `stop_req_o[k]` is high for every stage up to and including the current stage k. Stage k advances when `ack_i[k]` is high. The mode keeps showing the run mode until `ack_i[3]` completes the entry.
- R7: Address 4 logs entries: bit0 an entry started, bits 1..4 stages 0..3 acknowledged, bit5 entry completed. Writing exactly 0x01 clears the log, and any other value has no effect. A bit set in the same cycle as a clear survives.
- R8: In STOP, option 0 gates all three clocks, 1 gates system and bus, 2 gates system only, and 3 gates bus only. Stop kinds 3 and 4 also gate the slow clock. Outside STOP and stop exit every clock enable is 1.
- R9: Address 5 is the timeout limit (reset 32). The counter starts at 0 when an entry begins and counts every entry cycle. The entry aborts on the first edge with no current acknowledge and count >= limit. On abort all requests drop, `stop_tmo_o` pulses for one cycle and the run mode is unchanged.
- R10: When the final acknowledge arrives on the same edge at which the limit would expire, the entry completes and no timeout is raised.
- R11: `wake_i` in STOP re-enables slow, bus and system clocks on three successive edges, dropping `stop_req_o[3]`, `[2]`, `[1]` with them. The next edge drops `stop_req_o[0]` and enters normal RUN.
- R12: A run-mode write and `sleep_req` on the same edge in a run mode: the write is handled and the stop request is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low power-on reset |
| bus_wr | input | 1 | register write strobe |
| bus_addr | input | AW | register address |
| bus_wdata | input | DW | write data |
| bus_rdata | output | DW | read data for bus_addr |
| sleep_req | input | 1 | core stop request |
| wake_i | input | 1 | wake-up from stop |
| ack_i | input | 4 | group acknowledges (masters, sys, bus, slow) |
| stop_req_o | output | 4 | group stop requests |
| sys_clk_en | output | 1 | system clock enable |
| bus_clk_en | output | 1 | bus clock enable |
| slow_clk_en | output | 1 | slow clock enable |
| mode_o | output | 8 | one-hot current mode |
| stop_tmo_o | output | 1 | stop acknowledge timeout pulse |
| err_o | output | 1 | sticky request error |

## Verification
The interesting collision is between the last acknowledge of the chain and the expiry of the timeout limit. The bench reaches it by holding the first three acknowledges high, so the chain reaches its last stage exactly as the count meets a small limit. It then raises the final acknowledge for that single edge only and expects STOP with no timeout pulse. The same set-up without the final acknowledge must abort. A cycle-accurate behavioural model checks every output on every clock, so an off-by-one in either path is caught. A second collision, a log clear meeting a log set and a run write meeting a stop request, is judged the same way.

// File: rtl/lp_mode_seq.sv
`timescale 1ns/1ps
module lp_mode_seq #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int TW = 8,
  parameter int TMO_RST = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sleep_req,
  input  logic          wake_i,
  input  logic [3:0]    ack_i,
  output logic [3:0]    stop_req_o,
  output logic          sys_clk_en,
  output logic          bus_clk_en,
  output logic          slow_clk_en,
  output logic [7:0]    mode_o,
  output logic          stop_tmo_o,
  output logic          err_o
);
  localparam int NG = 4;
  localparam logic [AW-1:0] A_PERM = AW'(0), A_RUN = AW'(1), A_CFG = AW'(2),
                            A_MODE = AW'(3), A_LOG = AW'(4), A_TMO = AW'(5), A_ERR = AW'(6);
  localparam logic [2:0] DEPTH_MAX = 3'(NG);

  typedef enum logic [1:0] {PH_RUN, PH_ENTER, PH_STOP, PH_EXIT} ph_t;

  ph_t           ph;
  logic [3:0]    permit;
  logic          locked;
  logic [1:0]    run_m;
  logic [4:0]    cfg;
  logic [2:0]    s_mode;
  logic [1:0]    s_opt;
  logic [2:0]    depth;
  logic [TW-1:0] tmo_lim, tmo_cnt;
  logic [5:0]    log_q, log_set;
  logic          err_q, gated, tmo_q;
  logic          run_ok, stop_ok;

  wire wr_run  = bus_wr && bus_addr == A_RUN;
  wire [1:0] run_code = bus_wdata[1:0];
  wire [1:0] stg = depth[1:0] - 2'd1;
  wire entry_go = ph == PH_RUN && !wr_run && sleep_req && stop_ok;
  wire go_ack   = ph == PH_ENTER && ack_i[stg];
  wire log_clr  = bus_wr && bus_addr == A_LOG && bus_wdata == DW'(1);
  wire err_set  = (wr_run && !(ph == PH_RUN && run_ok)) ||
                  (ph == PH_RUN && !wr_run && sleep_req && !stop_ok);

  always_comb begin
    case (run_code)
      2'd0:    run_ok = 1'b1;
      2'd2:    run_ok = permit[1] && run_m == 2'd0;
      2'd3:    run_ok = permit[0] && run_m == 2'd0;
      default: run_ok = 1'b0;
    endcase
    case (cfg[2:0])
      3'd0:    stop_ok = 1'b1;
      3'd2:    stop_ok = permit[1];
      3'd3:    stop_ok = permit[2];
      3'd4:    stop_ok = permit[3];
      default: stop_ok = 1'b0;
    endcase
    if (run_m == 2'd3) stop_ok = 1'b0;
  end

  always_comb begin
    log_set = '0;
    if (entry_go) log_set[0] = 1'b1;
    if (go_ack) begin
      log_set = log_set | (6'd1 << depth);
      if (depth == DEPTH_MAX) log_set[5] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_RUN;
      permit  <= '0;
      locked  <= 1'b0;
      run_m   <= 2'd0;
      cfg     <= '0;
      s_mode  <= '0;
      s_opt   <= '0;
      depth   <= '0;
      tmo_lim <= TW'(TMO_RST);
      tmo_cnt <= '0;
      log_q   <= '0;
      err_q   <= 1'b0;
      gated   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      tmo_q <= 1'b0;
      if (bus_wr && bus_addr == A_PERM && !locked) begin
        permit <= bus_wdata[3:0];
        locked <= 1'b1;
      end
      if (bus_wr && bus_addr == A_CFG) cfg <= bus_wdata[4:0];
      if (bus_wr && bus_addr == A_TMO) tmo_lim <= bus_wdata[TW-1:0];
      log_q <= (log_clr ? 6'd0 : log_q) | log_set;
      if (err_set) err_q <= 1'b1;
      case (ph)
        PH_RUN:
          if (wr_run) begin
            if (run_ok) run_m <= run_code;
          end else if (entry_go) begin
            ph      <= PH_ENTER;
            depth   <= 3'd1;
            tmo_cnt <= '0;
            s_mode  <= cfg[2:0];
            s_opt   <= cfg[4:3];
          end
        PH_ENTER:
          if (go_ack) begin
            if (depth == DEPTH_MAX) begin
              ph    <= PH_STOP;
              gated <= 1'b1;
            end else depth <= depth + 3'd1;
            if (tmo_cnt != '1) tmo_cnt <= tmo_cnt + 1'b1;
          end else if (tmo_cnt >= tmo_lim) begin
            ph    <= PH_RUN;
            depth <= '0;
            tmo_q <= 1'b1;
          end else tmo_cnt <= tmo_cnt + 1'b1;
        PH_STOP:
          if (wake_i) begin
            ph    <= PH_EXIT;
            depth <= DEPTH_MAX - 3'd1;
          end
        default: begin
          depth <= depth - 3'd1;
          if (depth == 3'd1) begin
            ph    <= PH_RUN;
            gated <= 1'b0;
            run_m <= 2'd0;
          end
        end
      endcase
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_req
    assign stop_req_o[g] = depth > 3'(g);
  end

  wire g_sys  = s_opt != 2'd3;
  wire g_bus  = s_opt != 2'd2;
  wire g_slow = s_opt == 2'd0 || s_mode == 3'd3 || s_mode == 3'd4;
  assign sys_clk_en  = !(gated && g_sys  && depth > 3'd1);
  assign bus_clk_en  = !(gated && g_bus  && depth > 3'd2);
  assign slow_clk_en = !(gated && g_slow && depth > 3'd3);

  always_comb begin
    if (ph == PH_STOP || ph == PH_EXIT) mode_o = 8'h02;
    else case (run_m)
      2'd2:    mode_o = 8'h04;
      2'd3:    mode_o = 8'h80;
      default: mode_o = 8'h01;
    endcase
  end

  assign stop_tmo_o = tmo_q;
  assign err_o      = err_q;

  always_comb begin
    case (bus_addr)
      A_PERM:  bus_rdata = DW'(permit);
      A_RUN:   bus_rdata = DW'(run_m);
      A_CFG:   bus_rdata = DW'(cfg);
      A_MODE:  bus_rdata = DW'(mode_o);
      A_LOG:   bus_rdata = DW'(log_q);
      A_TMO:   bus_rdata = DW'(tmo_lim);
      A_ERR:   bus_rdata = DW'(err_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lp_mode_seq_chk.sv
`timescale 1ns/1ps
module lp_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] mode_o,
  input logic [3:0] stop_req_o,
  input logic       sys_clk_en,
  input logic       bus_clk_en,
  input logic       slow_clk_en,
  input logic       stop_tmo_o,
  input logic       err_o,
  input logic [3:0] permit,
  input logic       locked,
  input logic [5:0] log_q
);
  // R1
  perm_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> $stable(permit));
  // R2
  mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_o) == 1);
  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  // R7
  log_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_q[5] |-> log_q[4]);
  // R8
  gate_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_clk_en || !bus_clk_en || !slow_clk_en) |-> mode_o == 8'h02);
  // R9
  tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_tmo_o |-> (stop_req_o == 4'd0 && mode_o != 8'h02));
  // R9
  tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_tmo_o |=> !stop_tmo_o);
endmodule

bind lp_mode_seq lp_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .stop_req_o(stop_req_o),
  .sys_clk_en(sys_clk_en), .bus_clk_en(bus_clk_en), .slow_clk_en(slow_clk_en),
  .stop_tmo_o(stop_tmo_o), .err_o(err_o), .permit(permit), .locked(locked), .log_q(log_q)
);

// File: tb/lp_mode_seq_test.sv
`timescale 1ns/1ps
module lp_mode_seq_test;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic sleep_req = 0, wake_i = 0;
  logic [3:0] ack_i = 0, stop_req_o;
  logic sys_clk_en, bus_clk_en, slow_clk_en, stop_tmo_o, err_o;
  logic [7:0] mode_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lp_mode_seq uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req), .wake_i(wake_i),
    .ack_i(ack_i), .stop_req_o(stop_req_o), .sys_clk_en(sys_clk_en), .bus_clk_en(bus_clk_en),
    .slow_clk_en(slow_clk_en), .mode_o(mode_o), .stop_tmo_o(stop_tmo_o), .err_o(err_o));

  // behavioural reference: phase 0 run, 1 entering, 2 stopped, 3 leaving
  int m_perm, m_lock, m_run, m_cfg, m_ph, m_dep, m_cnt, m_lim, m_log, m_err, m_gated, m_sm, m_op, m_pulse;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_perm = 0; m_lock = 0; m_run = 0; m_cfg = 0; m_ph = 0; m_dep = 0; m_cnt = 0;
      m_lim = 32; m_log = 0; m_err = 0; m_gated = 0; m_sm = 0; m_op = 0; m_pulse = 0;
    end else begin
      int set, code, sm;
      bit ok, wrun;
      set = 0; m_pulse = 0;
      wrun = bus_wr && bus_addr == 1;
      if (m_ph == 0) begin
        if (wrun) begin
          code = bus_wdata & 3;
          ok = code == 0 || (code == 2 && m_perm[1] && m_run == 0) || (code == 3 && m_perm[0] && m_run == 0);
          if (ok) m_run = code; else m_err = 1;
        end else if (sleep_req) begin
          sm = m_cfg & 7;
          ok = (sm == 0 || (sm == 2 && m_perm[1]) || (sm == 3 && m_perm[2]) || (sm == 4 && m_perm[3])) && m_run != 3;
          if (ok) begin
            m_ph = 1; m_dep = 1; m_cnt = 0; m_sm = sm; m_op = (m_cfg >> 3) & 3; set = 1;
          end else m_err = 1;
        end
      end else begin
        if (wrun) m_err = 1;
        if (m_ph == 1) begin
          if (ack_i[m_dep-1]) begin
            set = set | (1 << m_dep);
            if (m_dep == 4) begin set = set | 32; m_ph = 2; m_gated = 1; end
            else m_dep++;
            if (m_cnt < 255) m_cnt++;
          end else if (m_cnt >= m_lim) begin
            m_ph = 0; m_dep = 0; m_pulse = 1;
          end else m_cnt++;
        end else if (m_ph == 2) begin
          if (wake_i) begin m_ph = 3; m_dep = 3; end
        end else begin
          m_dep--;
          if (m_dep == 0) begin m_ph = 0; m_gated = 0; m_run = 0; end
        end
      end
      m_log = ((bus_wr && bus_addr == 4 && bus_wdata == 1) ? 0 : m_log) | set;
      if (bus_wr && bus_addr == 0 && !m_lock) begin m_perm = bus_wdata & 15; m_lock = 1; end
      if (bus_wr && bus_addr == 2) m_cfg = bus_wdata & 31;
      if (bus_wr && bus_addr == 5) m_lim = bus_wdata;
    end
  end

  function automatic int m_mode();
    if (m_ph >= 2) return 2;
    return m_run == 2 ? 4 : (m_run == 3 ? 128 : 1);
  endfunction

  function automatic int m_rd(int a);
    case (a)
      0: return m_perm; 1: return m_run; 2: return m_cfg; 3: return m_mode();
      4: return m_log;  5: return m_lim; 6: return m_err; default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      int req;
      req = 0;
      for (int i = 0; i < 4; i++) if (m_dep > i) req = req | (1 << i);
      chk("R2 mode", mode_o, m_mode());
      chk("R6 stop_req", stop_req_o, req);
      chk("R8 sys_clk", sys_clk_en, !(m_gated && m_op != 3 && m_dep > 1));
      chk("R8 bus_clk", bus_clk_en, !(m_gated && m_op != 2 && m_dep > 2));
      chk("R8 slow_clk", slow_clk_en, !(m_gated && (m_op == 0 || m_sm == 3 || m_sm == 4) && m_dep > 3));
      chk("R9 tmo", stop_tmo_o, m_pulse);
      chk("R4 err", err_o, m_err);
      chk("R7 rdata", bus_rdata, m_rd(bus_addr));
    end
  end

  task automatic wr(int a, int d);
    bus_wr = 1; bus_addr = a[2:0]; bus_wdata = d[7:0];
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int a, output int v);
    bus_addr = a[2:0]; #0.5; v = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic sleep_pulse();
    sleep_req = 1; @(negedge clk); sleep_req = 0;
  endtask

  task automatic wake_all();
    wake_i = 1; @(negedge clk); wake_i = 0; repeat (4) @(negedge clk);
  endtask

  initial begin
    int v;
    @(negedge clk); @(negedge clk);
    chk("R2 reset mode", mode_o, 8'h01);
    rd(0, v); chk("R1 reset permit", v, 0);
    rd(5, v); chk("R9 reset limit", v, 32);
    rst_n = 1; @(negedge clk);
    // R3 R4: unpermitted high-speed run
    wr(1, 3); chk("R3 hsrun refused", mode_o, 8'h01); chk("R4 err set", err_o, 1);
    do_reset();
    chk("R4 err cleared by reset", err_o, 0);
    // R1: write once
    wr(0, 8'h0B); wr(0, 8'h0F);
    rd(0, v); chk("R1 second write ignored", v, 8'h0B);
    wr(1, 3); chk("R3 hsrun", mode_o, 8'h80);
    wr(1, 2); chk("R3 vlpr from hsrun refused", mode_o, 8'h80); chk("R4 illegal transition", err_o, 1);
    wr(2, 0); sleep_pulse(); chk("R4 stop from hsrun refused", stop_req_o, 0);
    wr(1, 0); chk("R3 back to run", mode_o, 8'h01);
    wr(2, 3); sleep_pulse(); chk("R5 ll stop not permitted", stop_req_o, 0);
    // R12: run write with sleep_req on the same edge
    wr(2, 0);
    sleep_req = 1; wr(1, 3); sleep_req = 0;
    chk("R12 write wins", mode_o, 8'h80); chk("R12 no entry", stop_req_o, 0);
    wr(1, 0);
    do_reset();
    wr(0, 8'h0F);
    // R6 R7 R8 R11: stepwise entry, full stop
    wr(2, 0); wr(4, 1);
    sleep_pulse();
    chk("R6 stage0 request", stop_req_o, 4'b0001); chk("R6 mode still run", mode_o, 8'h01);
    rd(4, v); chk("R7 entry started", v, 8'h01);
    ack_i = 4'b0001; @(negedge clk); ack_i = 0;
    chk("R6 stage1 request", stop_req_o, 4'b0011);
    rd(4, v); chk("R7 masters acked", v, 8'h03);
    @(negedge clk); chk("R6 waits for ack", stop_req_o, 4'b0011);
    ack_i = 4'hF; repeat (3) @(negedge clk); ack_i = 0;
    chk("R6 stopped", mode_o, 8'h02);
    chk("R8 opt0 gates all", {sys_clk_en, bus_clk_en, slow_clk_en}, 3'b000);
    rd(4, v); chk("R7 complete", v, 8'h3F);
    wr(4, 2); rd(4, v); chk("R7 other value ignored", v, 8'h3F);
    wake_i = 1; @(negedge clk); wake_i = 0;
    chk("R11 slow first", {sys_clk_en, bus_clk_en, slow_clk_en}, 3'b001);
    chk("R11 req3 dropped", stop_req_o, 4'b0111);
    @(negedge clk); chk("R11 bus second", {sys_clk_en, bus_clk_en, slow_clk_en}, 3'b011);
    @(negedge clk); chk("R11 sys third", {sys_clk_en, bus_clk_en, slow_clk_en}, 3'b111);
    @(negedge clk); chk("R11 run again", mode_o, 8'h01); chk("R11 released", stop_req_o, 0);
    wr(4, 1); rd(4, v); chk("R7 cleared", v, 0);
    // R8: option 2 with low-leakage stop
    wr(2, (2 << 3) | 3); ack_i = 4'hF; sleep_pulse(); repeat (4) @(negedge clk); ack_i = 0;
    chk("R8 opt2 ll", {sys_clk_en, bus_clk_en, slow_clk_en}, 3'b010);
    wake_all();
    // R8: option 3 normal stop
    wr(2, 3 << 3); ack_i = 4'hF; sleep_pulse(); repeat (4) @(negedge clk); ack_i = 0;
    chk("R8 opt3", {sys_clk_en, bus_clk_en, slow_clk_en}, 3'b101);
    wake_all();
    // R5: stop from very-low-power run
    wr(1, 2); wr(2, 2); ack_i = 4'h7; sleep_pulse();
    @(negedge clk); chk("R5 vlpr shown while entering", mode_o, 8'h04);
    ack_i = 4'hF; repeat (3) @(negedge clk); ack_i = 0;
    chk("R5 vlp stop", mode_o, 8'h02);
    wake_all(); chk("R11 wakes to normal run", mode_o, 8'h01);
    // R9: timeout with limit 5
    wr(5, 5); wr(2, 0); wr(4, 1);
    sleep_pulse(); repeat (5) @(negedge clk);
    chk("R9 still entering", stop_req_o, 4'b0001); chk("R9 no pulse yet", stop_tmo_o, 0);
    @(negedge clk);
    chk("R9 aborted", stop_req_o, 0); chk("R9 pulse", stop_tmo_o, 1); chk("R9 stays run", mode_o, 8'h01);
    rd(4, v); chk("R9 log start only", v, 8'h01);
    @(negedge clk); chk("R9 pulse one cycle", stop_tmo_o, 0);
    // R10: final ack meets expiry
    wr(5, 3); wr(4, 1); ack_i = 4'h7; sleep_pulse();
    repeat (3) @(negedge clk); ack_i = 4'hF; @(negedge clk); ack_i = 0;
    chk("R10 completion wins", mode_o, 8'h02); chk("R10 no pulse", stop_tmo_o, 0);
    wake_all();
    ack_i = 4'h7; sleep_pulse(); repeat (4) @(negedge clk); ack_i = 0;
    chk("R10 without final ack aborts", stop_tmo_o, 1);
    // R7: clear and set on the same edge
    wr(4, 1); bus_wr = 1; bus_addr = 4; bus_wdata = 1; sleep_req = 1; @(negedge clk);
    bus_wr = 0; sleep_req = 0;
    rd(4, v); chk("R7 set beats clear", v, 8'h01);
    repeat (8) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL R6 watchdog expired act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule